// File: doc/BRIEF.md
# Word Serializer with Internal Loopback Select

This block turns a stream of 10-bit parallel words into a serial bit stream. It runs entirely on the bit clock. An internal divide-by-ten phase counter marks one cycle in every ten as the byte strobe. On that edge the input word is captured into a holding register. A fixed number of bit periods later, the word moves into a shift register, which sends it out least significant bit first, one bit per clock.

The same block also steers the serial paths for self-test. In normal mode the serial stream goes to the external serial output and the receiver input follows the external serial input. In loopback mode the receiver input takes the transmit stream instead, and the external output is parked at logic 1. The loopback request is asynchronous to the block. It is synchronized first, and the mode changes only where one word ends and the next begins, so neither path ever sees part of a word.

Top module: `serial_tx_loop`

## Requirements
- R1: During reset, and after reset until the first captured word begins shifting, the external serial output is logic 1.
- R2: `byte_stb` is high in exactly one cycle of every ten. It is high in the cycle before the first clock edge after reset is released, so that edge captures the first word.
- R3: Each word is sent least significant bit first. Bit k of a word is on the serial stream k cycles after bit 0.
- R4: Bit 0 of a captured word appears on the serial stream 4 bit periods after the edge that captured it. This latency is the same for every word, and consecutive words follow with no gap.
- R5: With the effective mode normal, `ser_out` carries the transmit stream and `rx_bit` equals `ser_in`.
- R6: With the effective mode loopback, `ser_out` is logic 1 and `rx_bit` carries the transmit stream.
- R7: `loop_en` passes through a two-stage synchronizer. The effective mode changes only on a word-load edge, and that edge uses the request sampled two edges earlier.
- R8: `tx_word` is captured only on the edge that ends a cycle with `byte_stb` high. Changes to `tx_word` in any other cycle have no effect on the serial stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | 10 | Parallel word to transmit, bit 0 sent first |
| byte_stb | output | 1 | High in the cycle whose closing edge captures `tx_word` |
| loop_en | input | 1 | Loopback request, asynchronous |
| ser_in | input | 1 | External serial input |
| ser_out | output | 1 | External serial output |
| rx_bit | output | 1 | Serial input selected for the receiver |

## Verification
The bench changes `tx_word` on every cycle, not only at word boundaries. A design that captured the word at the wrong phase, or that let the holding register follow its input, would send bits mixed from several words. The bench toggles `loop_en` at arbitrary points inside words. A design that switched paths immediately, or that skipped the synchronizer delay, would send a word that is partly real data and partly parked ones, and the loopback and normal paths would disagree from the reference for some bits. The bench also compares the idle level and the exact first-bit cycle after reset. An off-by-one load position or a shift register that resets to zero would show up at once.

// File: rtl/sloop_pkg.sv
package sloop_pkg;

  // Modulo increment used by the phase counter.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Bit periods from capture edge to first serial bit.
  function automatic int unsigned first_bit_delay(input int unsigned load_ph);
    return load_ph;
  endfunction

endpackage

// File: rtl/byte_phase_gen.sv
module byte_phase_gen #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned LOAD_PH = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic latch_evt,
  output logic load_evt
);
  import sloop_pkg::*;
  localparam int unsigned PH_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= PH_W'(wrap_inc(int'(ph_q), WORD_W));
  end

  assign latch_evt = (ph_q == '0);
  assign load_evt  = (ph_q == PH_W'(LOAD_PH));

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !latch_evt); // R2

  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt); // R4

endmodule

// File: rtl/tx_word_path.sv
module tx_word_path #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_evt,
  input  logic              load_evt,
  input  logic [WORD_W-1:0] word_in,
  output logic              tx_bit
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shreg_q;
  logic              started_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '1;
    else if (latch_evt) hold_q <= word_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q   <= '1;
      started_q <= 1'b0;
    end else if (load_evt) begin
      shreg_q   <= hold_q;
      started_q <= 1'b1;
    end else begin
      shreg_q   <= {1'b1, shreg_q[WORD_W-1:1]};
    end
  end

  assign tx_bit = shreg_q[0];

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> tx_bit); // R1

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (tx_bit == $past(hold_q[0]))); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(hold_q)); // R8

endmodule

// File: rtl/loop_select.sv
module loop_select #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic loop_req,
  input  logic tx_bit,
  input  logic ext_in,
  output logic ext_out,
  output logic rx_bit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_sync;
  logic                   mode_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= loop_req;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], loop_req};
      end
    end
  endgenerate

  assign req_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (load_evt) mode_q <= req_sync;
  end

  assign ext_out = mode_q ? 1'b1   : tx_bit;
  assign rx_bit  = mode_q ? tx_bit : ext_in;

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(load_evt)); // R7

  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !ext_out) |-> 1'b0); // R6

endmodule

// File: rtl/serial_tx_loop.sv
module serial_tx_loop #(
  parameter int unsigned WORD_W      = 10,
  parameter int unsigned LOAD_PH     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_word,
  output logic              byte_stb,
  input  logic              loop_en,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              rx_bit
);
  logic latch_evt;
  logic load_evt;
  logic tx_bit;

  byte_phase_gen #(.WORD_W(WORD_W), .LOAD_PH(LOAD_PH)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_evt (latch_evt),
    .load_evt  (load_evt)
  );

  tx_word_path #(.WORD_W(WORD_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_evt (latch_evt),
    .load_evt  (load_evt),
    .word_in   (tx_word),
    .tx_bit    (tx_bit)
  );

  loop_select #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .loop_req (loop_en),
    .tx_bit   (tx_bit),
    .ext_in   (ser_in),
    .ext_out  (ser_out),
    .rx_bit   (rx_bit)
  );

  assign byte_stb = latch_evt;

  AST_STB_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_evt && load_evt)); // R4

endmodule

// File: tb/serial_tx_loop_bench.sv
module serial_tx_loop_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] tx_word = 10'h3FF;
  logic       loop_en = 1'b0;
  logic       ser_in = 1'b0;
  logic       byte_stb, ser_out, rx_bit;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  serial_tx_loop u_serial_tx_loop (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .byte_stb(byte_stb),
    .loop_en(loop_en), .ser_in(ser_in), .ser_out(ser_out), .rx_bit(rx_bit)
  );

  // Behavioural reference model
  int         m_ph = 0;
  int         m_idx = 0;
  bit         m_loaded = 0;
  logic [9:0] m_cur = '1;
  logic [9:0] m_q[$];
  bit         m_s1 = 0, m_s2 = 0, m_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_loaded = 0; m_cur = '1; m_q.delete();
      m_s1 = 0; m_s2 = 0; m_mode = 0;
    end else begin
      if (m_ph == 0) m_q.push_back(tx_word);            // R8 capture point
      if (m_ph == 4) begin                               // R4 fixed load phase
        m_cur = m_q.pop_front(); m_idx = 0; m_loaded = 1;
        m_mode = m_s2;                                   // R7 boundary switch
      end else m_idx++;
      m_s2 = m_s1; m_s1 = loop_en;
      m_ph = (m_ph + 1) % 10;
    end
  end

  function automatic bit exp_tx();
    if (!m_loaded || m_idx >= 10) return 1'b1;
    return m_cur[m_idx];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit t;
    t = exp_tx();
    check("R2 byte_stb", byte_stb, (m_ph == 0));
    if (m_mode) begin
      check("R6 ser_out parked", ser_out, 1'b1);
      check("R6,R7 rx_bit wrapped", rx_bit, t);
    end else begin
      check(m_loaded ? "R3,R4,R5,R8 ser_out" : "R1 ser_out idle", ser_out, t);
      check("R5,R7 rx_bit external", rx_bit, ser_in);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    ser_in = 1'b1;
    #0.1;
    check("R1 reset level", ser_out, 1'b1);
    check("R5 reset rx", rx_bit, 1'b1);
    rst_n = 1'b1;
    // Phase 1: normal mode, word changes every cycle
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      compare_all();
      tx_word = 10'($urandom);
      ser_in  = 1'($urandom);
    end
    // Phase 2: directed words: walking one, LSB-first visibility
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      compare_all();
      tx_word = 10'(1 << (c % 10));
      ser_in  = 1'($urandom);
    end
    // Phase 3: loopback toggled at arbitrary points
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      compare_all();
      tx_word = 10'($urandom);
      ser_in  = 1'($urandom);
      if (($urandom % 13) == 0) loop_en = ~loop_en;
    end
    // Phase 4: reset mid-stream, idle after reset
    @(negedge clk);
    rst_n = 1'b0; loop_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ser_out in reset", ser_out, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      compare_all();
      tx_word = 10'($urandom);
      ser_in  = 1'($urandom);
      if (c == 150) loop_en = 1'b0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule